// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller side of a byte-wide mailbox through which a host reaches a 256-entry internal register space. The host has two port selections. Selection 0 is the data port. Selection 1 returns the status byte on a read and takes a command byte on a write. Every byte the host writes is latched and raises the input-full flag. After a fixed number of cycles the sequencer consumes the byte and the flag drops. The host polls that flag before every write, and it polls the output-full flag before it reads a result.

Reading a register takes two bytes from the host: a read command, then the address. The block then issues a single-cycle read strobe to the register file. It loads the returned value into the outgoing data register and sets output-full. Writing a register takes three bytes: a write command, the address and the value. The block then issues one write strobe. Two further commands set and clear a burst flag. A query command answers with a zero byte, because no event source is connected.

Top module: `ec_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00 and the block issues neither register strobe.
- R2: A host write to either port sets the input-full flag. The flag stays set for exactly CONSUME_LAT cycles and then clears. The status byte's command bit shows 1 if the last byte came through port selection 1 and 0 if it came through selection 0.
- R3: The status byte, read with hostSel=1, holds output-full in bit 0, input-full in bit 1, a pending-event bit in bit 2 (always 0), the command bit in bit 3 and the burst flag in bit 4. Bits 7:5 read 0. A read with hostSel=0 returns the outgoing data register.
- R4: Command 0x80 followed by an address byte on the data port issues exactly one read strobe at that address. Two cycles after the strobe, the returned value sits in the outgoing data register and output-full is set.
- R5: Command 0x81 followed by an address byte and then a data byte issues exactly one write strobe, carrying that address and that data. The read and write strobes are never high together, and a write strobe never lasts more than one cycle.
- R6: A host read of the data port (hostRd with hostSel=0) clears output-full. Reading the status port leaves it unchanged.
- R7: Command 0x82 sets the burst flag and command 0x83 clears it.
- R8: Command 0x84 loads 0x00 into the outgoing data register and sets output-full.
- R9: A command byte with any other code is dropped. A data byte that follows it causes no strobe.
- R10: A command byte that arrives part-way through a sequence abandons that sequence and starts the new one. The abandoned sequence never issues its write.
- R11: A data byte written while no sequence is open is ignored and causes no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostWr | input | 1 | Host write strobe, one byte per high cycle |
| hostRd | input | 1 | Host read strobe, used to clear output-full |
| hostSel | input | 1 | Port select: 0 data, 1 status/command |
| hostWdata | input | DATA_W | Byte written by the host |
| hostRdata | output | DATA_W | Status byte or outgoing data, chosen by hostSel |
| regAddr | output | ADDR_W | Register-file address |
| regWdata | output | DATA_W | Register-file write data |
| regWe | output | 1 | Register-file write strobe |
| regRe | output | 1 | Register-file read strobe |
| regRdata | input | DATA_W | Register-file read data, valid one cycle after regRe |

## Verification
The hardest case to reach is a command that arrives after a write sequence has taken its address but before its data. The host must interleave the sequences while still honouring the input-full handshake, or the abort cannot be told apart from an overrun. The bench therefore sends 0x81 and an address and waits for input-full to clear. It then sends a complete read of a different, preloaded address. Finally it checks that the abandoned address still holds its old value, that the write-strobe count has not moved, and that a trailing data byte is dropped.

// File: rtl/ec_mailbox_pkg.sv
package ec_mailbox_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_RD_ADDR,
    SEQ_RD_WAIT,
    SEQ_WR_ADDR,
    SEQ_WR_DATA
  } seq_e;

  // strobes from control to datapath
  typedef struct packed {
    logic consume;
    logic latchAddr;
    logic regRead;
    logic regWrite;
    logic loadOut;
    logic loadQuery;
    logic burstOn;
    logic burstOff;
  } ctl_t;

  localparam logic [7:0] CMD_READ      = 8'h80;
  localparam logic [7:0] CMD_WRITE     = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY     = 8'h84;

  localparam int ST_OBF   = 0;
  localparam int ST_IBF   = 1;
  localparam int ST_EVT   = 2;
  localparam int ST_CMD   = 3;
  localparam int ST_BURST = 4;

endpackage

// File: rtl/ec_mailbox_ctrl.sv
module ec_mailbox_ctrl
  import ec_mailbox_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CONSUME_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWr,
  input  logic              ibFull,
  input  logic              isCmd,
  input  logic [DATA_W-1:0] inByte,
  output ctl_t              ctl
);

  localparam int CW = $clog2(CONSUME_LAT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(CONSUME_LAT - 1);

  logic [CW-1:0] cnt;
  seq_e          state;
  seq_e          nxt;
  seq_e          eff;

  // consumption latency counter, restarted by every host write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (hostWr)         cnt <= CNT_LOAD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    ctl = '0;
    nxt = state;
    eff = state;
    if (state == SEQ_RD_WAIT) begin
      ctl.loadOut = 1'b1;
      eff         = SEQ_IDLE;
      nxt         = SEQ_IDLE;
    end
    ctl.consume = ibFull && (cnt == '0);
    if (ctl.consume) begin
      if (isCmd) begin
        case (inByte[7:0])
          CMD_READ:      nxt = SEQ_RD_ADDR;
          CMD_WRITE:     nxt = SEQ_WR_ADDR;
          CMD_BURST_ON:  begin ctl.burstOn   = 1'b1; nxt = SEQ_IDLE; end
          CMD_BURST_OFF: begin ctl.burstOff  = 1'b1; nxt = SEQ_IDLE; end
          CMD_QUERY:     begin ctl.loadQuery = 1'b1; nxt = SEQ_IDLE; end
          default:       nxt = SEQ_IDLE;
        endcase
      end else begin
        case (eff)
          SEQ_RD_ADDR: begin ctl.regRead   = 1'b1; nxt = SEQ_RD_WAIT; end
          SEQ_WR_ADDR: begin ctl.latchAddr = 1'b1; nxt = SEQ_WR_DATA; end
          SEQ_WR_DATA: begin ctl.regWrite  = 1'b1; nxt = SEQ_IDLE;    end
          default:     nxt = SEQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ec_mailbox_dp.sv
module ec_mailbox_dp
  import ec_mailbox_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] inByte,
  output logic              isCmd,
  output logic              ibFull,
  output logic              obFull,
  output logic              burst,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataOut;
  logic [DATA_W-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inByte <= '0;
      isCmd  <= 1'b0;
      ibFull <= 1'b0;
    end else if (hostWr) begin
      inByte <= hostWdata;
      isCmd  <= hostSel;
      ibFull <= 1'b1;
    end else if (ctl.consume) begin
      ibFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addrHold <= '0;
    else if (ctl.latchAddr) addrHold <= inByte[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataOut <= '0;
      obFull  <= 1'b0;
    end else if (ctl.loadQuery) begin
      dataOut <= '0;
      obFull  <= 1'b1;
    end else if (ctl.loadOut) begin
      dataOut <= regRdata;
      obFull  <= 1'b1;
    end else if (hostRd && !hostSel) begin
      obFull  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            burst <= 1'b0;
    else if (ctl.burstOn)  burst <= 1'b1;
    else if (ctl.burstOff) burst <= 1'b0;
  end

  always_comb begin
    status           = '0;
    status[ST_OBF]   = obFull;
    status[ST_IBF]   = ibFull;
    status[ST_EVT]   = 1'b0;
    status[ST_CMD]   = isCmd;
    status[ST_BURST] = burst;
  end

  assign hostRdata = hostSel ? status : dataOut;
  assign regAddr   = ctl.regRead ? inByte[ADDR_W-1:0] : addrHold;
  assign regWdata  = inByte;
  assign regWe     = ctl.regWrite;
  assign regRe     = ctl.regRead;

endmodule

// File: rtl/ec_mailbox.sv
module ec_mailbox
  import ec_mailbox_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int CONSUME_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  ctl_t              ctl;
  logic [DATA_W-1:0] inByte;
  logic              isCmd;
  logic              ibFull;
  logic              obFull;
  logic              burst;

  ec_mailbox_ctrl #(.DATA_W(DATA_W), .CONSUME_LAT(CONSUME_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .ibFull(ibFull),
    .isCmd(isCmd), .inByte(inByte), .ctl(ctl)
  );

  ec_mailbox_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .inByte(inByte), .isCmd(isCmd), .ibFull(ibFull), .obFull(obFull),
    .burst(burst), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRe(regRe), .regRdata(regRdata)
  );

endmodule

// File: rtl/ec_mailbox_chk.sv
module ec_mailbox_chk (
  input logic clk,
  input logic rst_n,
  input logic hostWr,
  input logic regWe,
  input logic regRe,
  input logic ibFull,
  input logic obFull
);

  AST_IBF_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hostWr |=> ibFull); // R2

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    regRe |-> ##2 obFull); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWe && regRe)); // R5

  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    regWe |=> !regWe); // R5

endmodule

bind ec_mailbox ec_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .regWe(regWe),
  .regRe(regRe), .ibFull(ibFull), .obFull(obFull)
);

// File: tb/ec_mailbox_bench.sv
module ec_mailbox_bench;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic       hostSel = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [7:0] regAddr;
  logic [7:0] regWdata;
  logic       regWe;
  logic       regRe;
  logic [7:0] regRdata;

  int checks = 0;
  int fails = 0;
  int weCnt = 0;
  int reCnt = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  ec_mailbox #(.DATA_W(8), .ADDR_W(8), .CONSUME_LAT(LAT)) u_ec_mailbox (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostRd(hostRd),
    .hostSel(hostSel), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  // register file model with one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      regRdata <= 8'h00;
    end else begin
      if (regWe) begin mem[regAddr] <= regWdata; weCnt <= weCnt + 1; end
      if (regRe) begin regRdata <= mem[regAddr]; reCnt <= reCnt + 1; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic getStatus(output logic [7:0] s);
    hostSel = 1'b1;
    #1 s = hostRdata;
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] b);
    @(negedge clk);
    hostSel = sel; hostWdata = b; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic waitIbf();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      getStatus(s);
      if (!s[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic waitObf();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      getStatus(s);
      if (s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic send(input logic sel, input logic [7:0] b);
    hostWrite(sel, b);
    waitIbf();
  endtask

  task automatic readData(output logic [7:0] d);
    @(negedge clk);
    hostSel = 1'b0; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    send(1'b1, 8'h81); send(1'b0, a); send(1'b0, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] s;
    getStatus(s);
    check("R1 status after reset", s, 8'h00);
    check("R1 no strobes after reset", weCnt + reCnt, 0);
  endtask

  task automatic testLatency();
    logic [7:0] s;
    int we0 = weCnt, re0 = reCnt;
    hostWrite(1'b1, 8'h83);
    for (int i = 0; i < LAT; i++) begin
      getStatus(s);
      check("R2 ibf held", s[1], 1'b1);
      @(negedge clk);
    end
    getStatus(s);
    check("R2 ibf clears after latency", s[1], 1'b0);
    check("R2 cmd bit after command port", s[3], 1'b1);
    send(1'b0, 8'h5A);
    getStatus(s);
    check("R2 cmd bit after data port", s[3], 1'b0);
    repeat (3) @(negedge clk);
    check("R11 idle data byte no strobe", (weCnt - we0) + (reCnt - re0), 0);
  endtask

  task automatic testWrite();
    int we0 = weCnt;
    regWrite(8'h3C, 8'hA5);
    check("R5 write lands", mem[8'h3C], 8'hA5);
    check("R5 one write strobe", weCnt - we0, 1);
    regWrite(8'hFF, 8'h00);
    regWrite(8'h00, 8'hFF);
    check("R5 write top address", mem[8'hFF], 8'h00);
    check("R5 write address zero", mem[8'h00], 8'hFF);
  endtask

  task automatic testRead();
    logic [7:0] s, d;
    int re0 = reCnt;
    send(1'b1, 8'h80); send(1'b0, 8'h3C);
    waitObf();
    getStatus(s);
    check("R4 obf set after read", s[0], 1'b1);
    check("R4 one read strobe", reCnt - re0, 1);
    @(negedge clk); getStatus(s);
    check("R6 status read keeps obf", s[0], 1'b1);
    readData(d);
    check("R4 read value", d, 8'hA5);
    getStatus(s);
    check("R6 data read clears obf", s[0], 1'b0);
    send(1'b1, 8'h80); send(1'b0, 8'h00);
    waitObf(); readData(d);
    check("R4 read address zero", d, 8'hFF);
  endtask

  task automatic testBurstStatus();
    logic [7:0] s;
    send(1'b1, 8'h82);
    getStatus(s);
    check("R7 R3 burst on status", s, 8'h18);
    send(1'b1, 8'h83);
    getStatus(s);
    check("R7 R3 burst off status", s, 8'h08);
  endtask

  task automatic testQuery();
    logic [7:0] s, d;
    send(1'b1, 8'h84);
    @(negedge clk); getStatus(s);
    check("R8 query sets obf", s[0], 1'b1);
    readData(d);
    check("R8 query data", d, 8'h00);
  endtask

  task automatic testUnknown();
    logic [7:0] s;
    int we0 = weCnt, re0 = reCnt;
    send(1'b1, 8'h55); send(1'b0, 8'h12); send(1'b0, 8'h34);
    repeat (3) @(negedge clk);
    check("R9 unknown command no strobe", (weCnt - we0) + (reCnt - re0), 0);
    getStatus(s);
    check("R9 unknown command no obf", s[0], 1'b0);
  endtask

  task automatic testAbort();
    logic [7:0] d;
    int we0;
    regWrite(8'h40, 8'h11);
    we0 = weCnt;
    send(1'b1, 8'h81); send(1'b0, 8'h40);
    send(1'b1, 8'h80); send(1'b0, 8'h3C);
    waitObf(); readData(d);
    check("R10 new command reads", d, 8'hA5);
    send(1'b0, 8'h99);
    repeat (3) @(negedge clk);
    check("R10 abandoned write absent", mem[8'h40], 8'h11);
    check("R10 no write strobe", weCnt - we0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testLatency();
    testWrite();
    testRead();
    testBurstStatus();
    testQuery();
    testUnknown();
    testAbort();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule